// File: doc/BRIEF.md
# Processor Mode Control Register

An 8-bit memory-mapped control register that holds the external-bus options of a small microcontroller. These options are: ready-input enable, address-latch output enable, hold/acknowledge enable, recovery-cycle insertion and its length, the internal ROM bus-cycle length, a direct-page register switch and an external bus-cycle select bit. The CPU writes the register through a strobe with an address and data. It reads the register back through a combinational read port.

Several bits follow write rules of their own:

- Four bus-control bits take their reset value from the mode strap pin.
- Two of these bits latch off once they are cleared while the chip runs with an external bus.
- The direct-page switch may change only once after reset.

In single-chip mode, every bus-control function is forced off at the outputs, whatever the register holds. The block drives the decoded controls and the port-pin function selects to the bus-cycle engine and to the pin multiplexers.

Top module: `pmode_ctrl_reg`

## Requirements
- R1: During and after reset, bits 0 to 3 equal the level of `md0_i` and bits 4 to 7 are 0. Bit 0 is ready enable, bit 1 is address-latch enable, bit 2 is hold/acknowledge enable and bit 3 is recovery insert.
- R2: A write with `wr_en_i` high and `addr_i` equal to `REG_ADDR` (default 0x5F) updates the register at the clock edge. Writes to other addresses have no effect. `rdata_o` returns the stored byte when `addr_i` equals `REG_ADDR`, and 0 otherwise.
- R3: When `mode_i` is not 00, a write that changes bit 0 or bit 2 from 1 to 0 locks that bit at 0. Later writes of 1 to a locked bit are ignored until reset.
- R4: In single-chip mode (`mode_i` = 00), clearing bit 0 or bit 2 does not lock it, and a later write of 1 sets it again.
- R5: Bit 5 (direct-page switch, 1 = all four direct-page registers) changes only on the first write after reset that changes its value. After that change, writes leave it unchanged until reset.
- R6: With `mode_i` = 00, `pin_bus_sel_o` is 0 and `rcv_cycles_o` is 0, whatever the stored bits hold.
- R7: With `mode_i` not 00, `pin_bus_sel_o` carries four pin selects. Bit 0 (pin P3.0, ready input) equals register bit 0. Bit 1 (pin P4.0, address latch) equals register bit 1. Bit 2 (pin P4.2, acknowledge output) and bit 3 (pin P4.3, hold input) both equal register bit 2.
- R8: With `mode_i` not 00 and bit 3 set, `rcv_cycles_o` is 1 when bit 4 is 0 and 2 when bit 4 is 1. In every other case `rcv_cycles_o` is 0.
- R9: `rom_fast_o` (1 = 2φ internal ROM cycle) equals bit 6, except in microprocessor mode (`mode_i` = 10), where it is 0. Mode codes are 00 single-chip, 01 memory expansion and 10 microprocessor; 11 behaves as memory expansion.
- R10: `dpr_multi_o` equals bit 5 and `ext_cyc1_o` equals bit 7, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| md0_i | input | 1 | Mode strap pin; sets the reset value of bits 0 to 3 |
| mode_i | input | 2 | Processor mode code |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | ADDR_W | CPU address |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Read data; the register when the address matches, else 0 |
| pin_bus_sel_o | output | 4 | Per-pin bus-function select: P3.0, P4.0, P4.2, P4.3 |
| rcv_cycles_o | output | 2 | Recovery cycles to insert on external access (0, 1 or 2) |
| rom_fast_o | output | 1 | Internal ROM uses the 2φ cycle |
| dpr_multi_o | output | 1 | All four direct-page registers in use |
| ext_cyc1_o | output | 1 | External bus-cycle select bit 1 |

## Verification
The bench writes 0 and then 1 to the ready and hold bits, once in an external-bus mode and once in single-chip mode. A design that locks in the wrong mode, or that never locks, shows the wrong bit on read-back.

It toggles the direct-page switch several times after reset. A design that ignores the first change, or that allows a second one, returns a wrong bit 5.

It resets with the strap pin at both levels. A design with a fixed reset value then disagrees on bits 0 to 3. Random writes under random mode codes and addresses are checked against a bench model. This catches:
- pin selects leaking out in single-chip mode,
- a swapped hold/acknowledge pin,
- a ROM-cycle bit still honoured in microprocessor mode,
- a wrong recovery count.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_MPU    = 2'b10,
    MODE_RSVD   = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    CELL_PLAIN,
    CELL_STICKY,
    CELL_ONCE
  } cell_kind_e;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_RDY   = 0;
  localparam int unsigned B_ALE   = 1;
  localparam int unsigned B_HOLD  = 2;
  localparam int unsigned B_RCV   = 3;
  localparam int unsigned B_RCNT  = 4;
  localparam int unsigned B_DPR   = 5;
  localparam int unsigned B_ROM   = 6;
  localparam int unsigned B_EXT1  = 7;
  localparam int unsigned STRAP_N = 4;  // bits below this index reset to md0

  function automatic cell_kind_e kind_of(input int unsigned idx);
    if (idx == B_RDY || idx == B_HOLD) return CELL_STICKY;
    if (idx == B_DPR) return CELL_ONCE;
    return CELL_PLAIN;
  endfunction
endpackage

// File: rtl/pmode_bit_cell.sv
module pmode_bit_cell
  import pmode_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_PLAIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_val_i,
  input  logic wr_i,
  input  logic d_i,
  input  logic arm_i,
  output logic q_o
);
  logic q_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= rst_val_i;
      lock_q <= 1'b0;
    end else if (wr_i) begin
      case (KIND)
        CELL_STICKY: begin
          if (!lock_q) begin
            q_q <= d_i;
            if (q_q && !d_i && arm_i) lock_q <= 1'b1;
          end
        end
        CELL_ONCE: begin
          if (!lock_q && (d_i != q_q)) begin
            q_q    <= d_i;
            lock_q <= 1'b1;
          end
        end
        default: begin
          q_q    <= d_i;
          lock_q <= 1'b0;
        end
      endcase
    end
  end

  assign q_o = q_q;

  generate
    if (KIND == CELL_STICKY) begin : g_sticky_chk
      // R3
      lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |-> !q_q);
    end else if (KIND == CELL_ONCE) begin : g_once_chk
      // R5
      once_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> ($stable(q_q) && lock_q));
    end
  endgenerate
endmodule

// File: rtl/pmode_decode.sv
module pmode_decode
  import pmode_pkg::*;
(
  input  logic [REG_W-1:0] reg_i,
  input  logic [1:0]       mode_i,
  output logic [3:0]       pin_sel_o,
  output logic [1:0]       rcv_cycles_o,
  output logic             rom_fast_o,
  output logic             dpr_multi_o,
  output logic             ext_cyc1_o
);
  logic bus_on, mpu_mode;

  assign bus_on   = (mode_i != MODE_SINGLE);
  assign mpu_mode = (mode_i == MODE_MPU);

  always_comb begin
    pin_sel_o = '0;
    if (bus_on) begin
      pin_sel_o[0] = reg_i[B_RDY];
      pin_sel_o[1] = reg_i[B_ALE];
      pin_sel_o[2] = reg_i[B_HOLD];  // acknowledge out
      pin_sel_o[3] = reg_i[B_HOLD];  // hold in
    end
  end

  always_comb begin
    rcv_cycles_o = 2'd0;
    if (bus_on && reg_i[B_RCV]) rcv_cycles_o = reg_i[B_RCNT] ? 2'd2 : 2'd1;
  end

  assign rom_fast_o  = reg_i[B_ROM] && !mpu_mode;
  assign dpr_multi_o = reg_i[B_DPR];
  assign ext_cyc1_o  = reg_i[B_EXT1];
endmodule

// File: rtl/pmode_ctrl_reg.sv
module pmode_ctrl_reg
  import pmode_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h5F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              md0_i,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [3:0]        pin_bus_sel_o,
  output logic [1:0]        rcv_cycles_o,
  output logic              rom_fast_o,
  output logic              dpr_multi_o,
  output logic              ext_cyc1_o
);
  logic             hit, wr_hit, arm;
  logic [REG_W-1:0] reg_q;

  assign hit    = (addr_i == REG_ADDR);
  assign wr_hit = wr_en_i && hit;
  assign arm    = (mode_i != MODE_SINGLE);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    pmode_bit_cell #(.KIND(kind_of(i))) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rst_val_i((i < STRAP_N) ? md0_i : 1'b0),
      .wr_i     (wr_hit),
      .d_i      (wdata_i[i]),
      .arm_i    (arm),
      .q_o      (reg_q[i])
    );
  end

  assign rdata_o = hit ? reg_q : '0;

  pmode_decode u_dec (
    .reg_i       (reg_q),
    .mode_i      (mode_i),
    .pin_sel_o   (pin_bus_sel_o),
    .rcv_cycles_o(rcv_cycles_o),
    .rom_fast_o  (rom_fast_o),
    .dpr_multi_o (dpr_multi_o),
    .ext_cyc1_o  (ext_cyc1_o)
  );

  // R2
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (reg_q[B_EXT1] == $past(wdata_i[B_EXT1])));
  // R2
  wr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(reg_q));
  // R6
  single_chip_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SINGLE) |-> (pin_bus_sel_o == 4'd0 && rcv_cycles_o == 2'd0));
  // R7
  hold_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_bus_sel_o[2] == pin_bus_sel_o[3]);
  // R8
  rcv_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_cycles_o != 2'd3);
  // R9
  mpu_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MPU) |-> !rom_fast_o);
endmodule

// File: tb/pmode_ctrl_reg_tb.sv
module pmode_ctrl_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RA = 8'h5F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       md0 = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] addr = RA;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] pin_sel;
  logic [1:0] rcv;
  logic       rom_fast, dpr_multi, ext_cyc1;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_reg;
  logic       m_lk_rdy, m_lk_hold, m_dpr_used;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmode_ctrl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .md0_i(md0), .mode_i(mode),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_bus_sel_o(pin_sel), .rcv_cycles_o(rcv), .rom_fast_o(rom_fast),
    .dpr_multi_o(dpr_multi), .ext_cyc1_o(ext_cyc1)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic [7:0] r, input logic [1:0] m);
    if (m == 2'b00) return 4'd0;
    return {r[2], r[2], r[1], r[0]};
  endfunction

  function automatic logic [1:0] exp_rcv(input logic [7:0] r, input logic [1:0] m);
    if (m == 2'b00 || !r[3]) return 2'd0;
    return r[4] ? 2'd2 : 2'd1;
  endfunction

  task automatic model_write(input logic [7:0] d, input logic [1:0] m);
    if (!m_lk_rdy) begin
      if (m_reg[0] && !d[0] && m != 2'b00) m_lk_rdy = 1'b1;
      m_reg[0] = d[0];
    end
    if (!m_lk_hold) begin
      if (m_reg[2] && !d[2] && m != 2'b00) m_lk_hold = 1'b1;
      m_reg[2] = d[2];
    end
    if (!m_dpr_used && d[5] != m_reg[5]) begin
      m_reg[5] = d[5];
      m_dpr_used = 1'b1;
    end
    m_reg[1] = d[1]; m_reg[3] = d[3]; m_reg[4] = d[4];
    m_reg[6] = d[6]; m_reg[7] = d[7];
  endtask

  task automatic check_all();
    check("R2/R3/R5 rdata", rdata, (addr == RA) ? m_reg : 8'h00);
    check(mode == 2'b00 ? "R6 pins" : "R7 pins", {4'd0, pin_sel}, {4'd0, exp_pins(m_reg, mode)});
    check("R8 rcv", {6'd0, rcv}, {6'd0, exp_rcv(m_reg, mode)});
    check("R9 rom", {7'd0, rom_fast}, {7'd0, m_reg[6] && mode != 2'b10});
    check("R10 dpr", {7'd0, dpr_multi}, {7'd0, m_reg[5]});
    check("R10 ext", {7'd0, ext_cyc1}, {7'd0, m_reg[7]});
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; md0 = strap; wr_en = 1'b0; addr = RA;
    m_reg = {4'b0000, {4{strap}}};
    m_lk_rdy = 1'b0; m_lk_hold = 1'b0; m_dpr_used = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", rdata, m_reg);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rdata, m_reg);
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input logic [1:0] m);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; mode = m;
    @(posedge clk);
    if (we && a == RA) model_write(d, m);
    #1 wr_en = 1'b0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 strap low and high
    do_reset(1'b0);
    do_reset(1'b1);
    // R3 lock in expansion mode
    step(1'b1, RA, 8'h00, 2'b01);
    step(1'b1, RA, 8'hFF, 2'b01);
    check("R3 locked bits", {6'd0, rdata[2], rdata[0]}, 8'd0);
    // R5 second change refused
    step(1'b1, RA, 8'h00, 2'b01);
    check("R5 dpr held", {7'd0, rdata[5]}, 8'd1);
    // R4 no lock in single-chip
    do_reset(1'b1);
    step(1'b1, RA, 8'h00, 2'b00);
    step(1'b1, RA, 8'h05, 2'b00);
    check("R4 re-set", {6'd0, rdata[2], rdata[0]}, 8'd3);
    check("R6 pins off", {4'd0, pin_sel}, 8'd0);
    // R2 miss write
    step(1'b1, 8'h5E, 8'hA0, 2'b01);
    step(1'b0, RA, 8'hFF, 2'b01);
    check("R2 miss ignored", rdata, m_reg);
    // R9 mpu mode
    step(1'b1, RA, 8'h40, 2'b10);
    check("R9 mpu rom", {7'd0, rom_fast}, 8'd0);
    step(1'b0, RA, 8'h00, 2'b01);
    check("R9 expand rom", {7'd0, rom_fast}, 8'd1);
    // random
    for (int k = 0; k < 600; k++) begin
      if (k % 150 == 149) do_reset(1'($urandom));
      step(1'($urandom), ($urandom % 2) ? RA : 8'($urandom),
           8'($urandom), 2'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule